// File: doc/BRIEF.md
# Table-Write Staging Buffer

This block collects data bytes for a block-sized program-memory write before the memory is touched. Software-visible state is a 22-bit address pointer, loaded one byte at a time (low, high, upper), and an 8-bit data latch. Each table-write strobe copies the latch into one of 64 staging bytes. The six low pointer bits choose which staging byte is written. The remaining sixteen pointer bits are remembered as the number of the memory block that the staged bytes will go to. The strobe can also step the pointer in one of four ways, so a loop of strobes fills the buffer without reloading the pointer.

The staged bytes never reach the array through a table write. A separate commit request starts a stream towards the write engine. The stream carries the block number and all 64 bytes with their indices, in ascending order, under a valid/ready handshake. Once the last byte is taken, the staging bytes return to the erased value 0xFF, ready for the next block.

Top module: `twb_holding_buffer`

## Requirements
- R1: After reset the pointer is 0, the latch is 0, the block number is 0, every staging byte is 0xFF, and `busy` and `cmtValid` are low.
- R2: When `regWrEn` is high, `regSel` picks the target on the next edge: 0 loads pointer bits [7:0], 1 loads bits [15:8], 2 loads bits [21:16] from `regWrData[5:0]`, and 3 loads the latch. The other pointer bits keep their values.
- R3: An accepted table-write strobe stores the latch into the staging byte addressed by bits [5:0] of the write address. The write address is the pointer itself for modes 0, 1 and 2, and the pointer plus one for mode 3.
- R4: On an accepted strobe, `twMode` 0 leaves the pointer unchanged, 1 adds one after the write, 2 subtracts one after the write, and 3 adds one before the write. Each step carries or borrows across the full 22 bits and wraps modulo 2^22.
- R5: `cmtBlock` equals bits [21:6] of the write address of the most recent accepted table write, and it is kept across commits.
- R6: A commit request while idle raises `busy` and `cmtValid` from the next cycle. `cmtIndex` then runs 0 to 63 in order, with `cmtData` equal to that staging byte. The index advances only on a cycle where `cmtValid` and `cmtReady` are both high.
- R7: In the cycle after byte 63 is accepted, `busy` and `cmtValid` are low and every staging byte reads 0xFF in the next commit.
- R8: While `busy` is high, table-write strobes and commit requests are ignored: the pointer, staging bytes and block number do not change. Register writes still take effect.
- R9: If a strobe is accepted in the same cycle as a pointer byte write, the strobe's pointer update wins. If it coincides with a latch write, the previous latch value is the one staged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register byte write enable |
| regSel | input | 2 | Register target: 0 low, 1 high, 2 upper, 3 latch |
| regWrData | input | 8 | Register write data |
| twStrobe | input | 1 | Table-write strobe |
| twMode | input | 2 | Pointer step mode for the strobe |
| commitReq | input | 1 | Start streaming the staged block |
| ptrOut | output | 22 | Current pointer |
| latchOut | output | 8 | Current latch |
| busy | output | 1 | Commit in progress |
| cmtValid | output | 1 | Commit byte valid |
| cmtIndex | output | 6 | Index of the byte offered |
| cmtData | output | 8 | Staged byte offered |
| cmtBlock | output | 16 | Destination block number |
| cmtReady | input | 1 | Write engine accepts the offered byte |

## Verification
The bench targets pointer wrap at both ends of the 22-bit range. A design that drops the carry or borrow into the upper byte would show a wrong `ptrOut` at once, and its pre-increment would stage the byte at the wrong offset. It also drives collisions in a single cycle: a strobe with a pointer load, a strobe with a latch write, and a strobe with a commit start. A design with the wrong priority stages the wrong byte or keeps a stale pointer. Strobes issued during a commit, together with a ready signal that stalls irregularly, expose a buffer that accepts writes while busy, skips indices under back-pressure, or is not erased after the final byte. Any of these shows up in the bytes streamed by the following commit.

// File: rtl/twb_pkg.sv
package twb_pkg;
  typedef enum logic [1:0] {
    TW_HOLD    = 2'd0,
    TW_POSTINC = 2'd1,
    TW_POSTDEC = 2'd2,
    TW_PREINC  = 2'd3
  } twMode_e;

  typedef enum logic [1:0] {
    SEL_LOW   = 2'd0,
    SEL_HIGH  = 2'd1,
    SEL_UPPER = 2'd2,
    SEL_LATCH = 2'd3
  } regSel_e;

  typedef struct packed {
    logic twGo;      // accepted table write this cycle
    logic clearAll;  // final commit beat accepted, erase staging bytes
  } ctrlStrobe_t;
endpackage

// File: rtl/twb_ctrl.sv
module twb_ctrl
  import twb_pkg::*;
#(
  parameter int OFF_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             twStrobe,
  input  logic             commitReq,
  input  logic             cmtReady,
  output logic             busy,
  output logic [OFF_W-1:0] idx,
  output ctrlStrobe_t      strobes
);
  localparam logic [OFF_W-1:0] LAST = {OFF_W{1'b1}};

  logic lastBeat;
  assign lastBeat = busy && cmtReady && (idx == LAST);

  always_comb begin
    strobes.twGo     = twStrobe && !busy;
    strobes.clearAll = lastBeat;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (!busy) begin
      idx <= '0;
      if (commitReq) busy <= 1'b1;
    end else if (cmtReady) begin
      if (idx == LAST) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  assert_idle_index_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> idx == '0);
  assert_stall_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy && !cmtReady |=> busy && $stable(idx));
  assert_advance_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy && cmtReady && idx != LAST |=> busy && idx == $past(idx) + 1'b1);
  assert_finish_R7: assert property (@(posedge clk) disable iff (!rstN)
    busy && cmtReady && idx == LAST |=> !busy);
  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy && commitReq && !cmtReady |=> busy && $stable(idx));
endmodule

// File: rtl/twb_datapath.sv
module twb_datapath
  import twb_pkg::*;
#(
  parameter int PTR_W  = 22,
  parameter int OFF_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobe_t            strobes,
  input  logic                   regWrEn,
  input  logic [1:0]             regSel,
  input  logic [DATA_W-1:0]      regWrData,
  input  logic [1:0]             twMode,
  input  logic [OFF_W-1:0]       rdIdx,
  output logic [PTR_W-1:0]       ptr,
  output logic [DATA_W-1:0]      latch,
  output logic [DATA_W-1:0]      rdData,
  output logic [PTR_W-OFF_W-1:0] blockNum
);
  localparam int DEPTH = 1 << OFF_W;
  localparam int UP_W  = PTR_W - 16;

  twMode_e mode;
  regSel_e sel;
  logic [PTR_W-1:0] wrAddr, nextPtr;
  logic [DATA_W-1:0] hold [DEPTH];
  logic ptrByteWr;

  assign mode      = twMode_e'(twMode);
  assign sel       = regSel_e'(regSel);
  assign ptrByteWr = regWrEn && (sel != SEL_LATCH);

  always_comb begin
    wrAddr = (mode == TW_PREINC) ? ptr + 1'b1 : ptr;
    unique case (mode)
      TW_HOLD:    nextPtr = ptr;
      TW_POSTDEC: nextPtr = ptr - 1'b1;
      default:    nextPtr = ptr + 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr      <= '0;
      latch    <= '0;
      blockNum <= '0;
    end else begin
      if (strobes.twGo) begin
        ptr      <= nextPtr;
        blockNum <= wrAddr[PTR_W-1:OFF_W];
      end else if (ptrByteWr) begin
        unique case (sel)
          SEL_LOW:  ptr[7:0]      <= regWrData;
          SEL_HIGH: ptr[15:8]     <= regWrData;
          default:  ptr[PTR_W-1:16] <= regWrData[UP_W-1:0];
        endcase
      end
      if (regWrEn && sel == SEL_LATCH) latch <= regWrData;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : gHold
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        hold[g] <= '1;
      else if (strobes.clearAll)
        hold[g] <= '1;
      else if (strobes.twGo && wrAddr[OFF_W-1:0] == OFF_W'(g))
        hold[g] <= latch;
    end
  end

  assign rdData = hold[rdIdx];

  assert_postinc_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.twGo && (mode == TW_POSTINC || mode == TW_PREINC) |=> ptr == $past(ptr) + 1'b1);
  assert_postdec_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.twGo && mode == TW_POSTDEC |=> ptr == $past(ptr) - 1'b1);
  assert_ptr_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.twGo && !ptrByteWr |=> $stable(ptr));
  assert_block_kept_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.twGo |=> $stable(blockNum));
  assert_erase_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearAll |=> hold[0] == '1 && hold[DEPTH-1] == '1);
endmodule

// File: rtl/twb_holding_buffer.sv
module twb_holding_buffer
  import twb_pkg::*;
#(
  parameter int PTR_W  = 22,
  parameter int OFF_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWrEn,
  input  logic [1:0]             regSel,
  input  logic [DATA_W-1:0]      regWrData,
  input  logic                   twStrobe,
  input  logic [1:0]             twMode,
  input  logic                   commitReq,
  output logic [PTR_W-1:0]       ptrOut,
  output logic [DATA_W-1:0]      latchOut,
  output logic                   busy,
  output logic                   cmtValid,
  output logic [OFF_W-1:0]       cmtIndex,
  output logic [DATA_W-1:0]      cmtData,
  output logic [PTR_W-OFF_W-1:0] cmtBlock,
  input  logic                   cmtReady
);
  ctrlStrobe_t strobes;
  logic [OFF_W-1:0] idx;

  twb_ctrl #(.OFF_W(OFF_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .twStrobe(twStrobe), .commitReq(commitReq),
    .cmtReady(cmtReady), .busy(busy), .idx(idx), .strobes(strobes)
  );

  twb_datapath #(.PTR_W(PTR_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regWrEn(regWrEn),
    .regSel(regSel), .regWrData(regWrData), .twMode(twMode), .rdIdx(idx),
    .ptr(ptrOut), .latch(latchOut), .rdData(cmtData), .blockNum(cmtBlock)
  );

  assign cmtValid = busy;
  assign cmtIndex = idx;
endmodule

// File: tb/test_twb_holding_buffer.sv
module test_twb_holding_buffer;
  logic clk = 0, rstN = 0;
  logic regWrEn = 0, twStrobe = 0, commitReq = 0, cmtReady = 1;
  logic [1:0] regSel = 0, twMode = 0;
  logic [7:0] regWrData = 0;
  logic [21:0] ptrOut;
  logic [7:0] latchOut, cmtData;
  logic busy, cmtValid;
  logic [5:0] cmtIndex;
  logic [15:0] cmtBlock;

  always #2 clk = ~clk;  // 250 MHz

  twb_holding_buffer i_twb_holding_buffer (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .twStrobe(twStrobe), .twMode(twMode),
    .commitReq(commitReq), .ptrOut(ptrOut), .latchOut(latchOut),
    .busy(busy), .cmtValid(cmtValid), .cmtIndex(cmtIndex), .cmtData(cmtData),
    .cmtBlock(cmtBlock), .cmtReady(cmtReady)
  );

  // behavioural reference
  int mPtr, mLatch, mBlock, mIdx, mBusy;
  int mHold [64];
  int checks = 0, fails = 0, cycles = 0;
  bit randReady = 0;
  logic [7:0] lfsr = 8'h5B;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPtr = 0; mLatch = 0; mBlock = 0; mIdx = 0; mBusy = 0;
      foreach (mHold[i]) mHold[i] = 255;
    end else begin
      int oPtr, oLatch, addr, oBusy, oIdx;
      oPtr = mPtr; oLatch = mLatch; oBusy = mBusy; oIdx = mIdx;
      if (regWrEn && regSel == 3) mLatch = regWrData;
      if (twStrobe && !oBusy) begin
        addr = (twMode == 3) ? (oPtr + 1) % 4194304 : oPtr;
        mHold[addr % 64] = oLatch;
        mBlock = addr / 64;
        case (twMode)
          0: mPtr = oPtr;
          2: mPtr = (oPtr + 4194303) % 4194304;
          default: mPtr = (oPtr + 1) % 4194304;
        endcase
      end else if (regWrEn && regSel != 3) begin
        case (regSel)
          0: mPtr = (oPtr & 32'h3FFF00) | regWrData;
          1: mPtr = (oPtr & 32'h3F00FF) | (regWrData << 8);
          default: mPtr = (oPtr & 32'h00FFFF) | ((regWrData & 63) << 16);
        endcase
      end
      if (!oBusy) begin
        mIdx = 0;
        if (commitReq) mBusy = 1;
      end else if (cmtReady) begin
        if (oIdx == 63) begin
          mBusy = 0; mIdx = 0;
          foreach (mHold[i]) mHold[i] = 255;
        end else mIdx = oIdx + 1;
      end
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // compare every cycle away from the clock edge
  always @(negedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finishRun();
    end
    if (rstN) begin
      chk(ptrOut == mPtr[21:0], "R2/R4/R9", "ptr", ptrOut, mPtr);
      chk(latchOut == mLatch[7:0], "R2/R9", "latch", latchOut, mLatch);
      chk(cmtBlock == mBlock[15:0], "R5", "block", cmtBlock, mBlock);
      chk(busy == mBusy[0] && cmtValid == mBusy[0], "R6/R7/R8", "busy", busy, mBusy);
      if (mBusy) begin
        chk(cmtIndex == mIdx[5:0], "R6", "index", cmtIndex, mIdx);
        chk(cmtData == mHold[mIdx][7:0], "R3/R6/R7", "data", cmtData, mHold[mIdx]);
      end
    end
  end

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    cmtReady <= randReady ? lfsr[0] : 1'b1;
  end

  task automatic step(bit we, int sel, int d, bit tw, int md, bit cm);
    regWrEn = we; regSel = 2'(sel); regWrData = 8'(d);
    twStrobe = tw; twMode = 2'(md); commitReq = cm;
    @(negedge clk);
    regWrEn = 0; twStrobe = 0; commitReq = 0;
  endtask

  task automatic setPtr(int p);
    step(1, 0, p & 255, 0, 0, 0);
    step(1, 1, (p >> 8) & 255, 0, 0, 0);
    step(1, 2, (p >> 16) & 255, 0, 0, 0);
  endtask

  task automatic waitIdle();
    step(0, 0, 0, 0, 0, 0);
    while (busy) step(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    @(negedge clk);
    // R1: reset values
    chk(ptrOut == 0 && latchOut == 0 && cmtBlock == 0, "R1", "regs", ptrOut, 0);
    chk(!busy && !cmtValid, "R1", "busy", busy, 0);
    @(negedge clk); rstN = 1; @(negedge clk);
    // R1: erased buffer streamed before any write
    step(0, 0, 0, 0, 0, 1); waitIdle();
    // R2/R3/R4: modes near a block boundary
    setPtr(32'h3F123E);
    step(1, 3, 8'hA5, 0, 0, 0);
    step(0, 0, 0, 1, 1, 0);
    step(1, 3, 8'h11, 0, 0, 0);
    step(0, 0, 0, 1, 1, 0);          // crosses into next block
    step(1, 3, 8'h22, 0, 0, 0);
    step(0, 0, 0, 1, 3, 0);
    step(1, 3, 8'h33, 0, 0, 0);
    step(0, 0, 0, 1, 2, 0);
    step(0, 0, 0, 1, 0, 0);
    // R4: wrap both ways
    setPtr(32'h3FFFFF);
    step(0, 0, 0, 1, 1, 0);
    step(0, 0, 0, 1, 2, 0);
    step(0, 0, 0, 1, 3, 0);
    // R9: collisions
    step(1, 1, 8'h77, 1, 1, 0);
    step(1, 3, 8'h5C, 1, 2, 0);
    // R3/R5: fill a block with varied modes
    setPtr(32'h012340);
    for (int k = 0; k < 70; k++) begin
      step(1, 3, (k * 37 + 5) & 255, 0, 0, 0);
      step(0, 0, 0, 1, (k % 5 == 4) ? 3 : 1, 0);
    end
    // R6/R8: commit with stalls and strobes while busy
    randReady = 1;
    step(1, 3, 8'hE1, 1, 1, 1);      // strobe accepted with commit start
    for (int k = 0; k < 20; k++) step(k[0], 3, k, 1, k % 4, 1);
    waitIdle();
    // R7: buffer erased, block retained
    step(0, 0, 0, 0, 0, 1); waitIdle();
    randReady = 0;
    setPtr(32'h000004);
    step(1, 3, 8'h9D, 0, 0, 0);
    step(0, 0, 0, 1, 2, 0);
    step(0, 0, 0, 0, 0, 1); waitIdle();
    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule